// File: doc/BRIEF.md
# Coarse-Fine Time-to-Digital Encoder

This block is the digital back end of a two-stage time interval measurement. A coarse stage counts reference-clock periods from a start event to a stop event. A fine stage takes a snapshot of an external 16-tap delay line and turns it into a sub-period bin. The delay line covers one clock period, so each tap stands for one sixteenth of that period. The block joins both values into one 15-bit timestamp: 11 coarse bits above 4 fine bits. With a 3.2 ns reference period and 200 ps bins, this covers about 6.55 us.

Two coarse counters run side by side, one on each edge of the reference clock. The fine bin decides which counter is read. A hit in the first half of a period takes its coarse value from the falling-edge counter. A hit in the second half takes it from the rising-edge counter. In each case the counter read is one that changed half a period away from the hit. A start pulse arms the block. A stop pulse captures both counters and the tap snapshot. One cycle after that capture, the block presents the timestamp with a one-cycle valid strobe. Tap snapshots that are not a clean thermometer code set an error flag. A run longer than the coarse range sets an overflow flag and saturates the timestamp.

Top module: `tdc_coarse_fine_enc`

## Requirements
- R1: A synchronous active-high reset clears `valid_o`, `err_o`, `ovf_o` and `stamp_o` to zero and disarms the block. This holds even in the middle of a measurement.
- R2: A start pulse sampled on a rising edge arms the block. A stop sampled on the k-th rising edge after the start edge gives coarse value k-1 in `stamp_o[14:4]`.
- R3: The fine bin in `stamp_o[3:0]` equals the number of consecutive ones in `taps_i` counted upward from bit 0, where bit 0 is the earliest tap. A clean code for bin b is (1<<b)-1.
- R4: For fine bins 0 to 7 the coarse value comes from the falling-edge counter minus one. For bins 8 to 15 it comes from the rising-edge counter. Both paths yield k-1, including for bins 7 and 8 at the half-period boundary and bins 0 and 15 at the clock edges.
- R5: `valid_o` is a one-cycle pulse on the rising edge after the stop edge. Between pulses, `stamp_o`, `err_o` and `ovf_o` hold their last values.
- R6: A stop pulse is ignored when the block is not armed, or when it comes on the same edge as a start (start wins). The first accepted stop disarms the block, so a later stop is ignored.
- R7: A start while the block is armed restarts the measurement from zero.
- R8: A tap snapshot that is not of the form (1<<b)-1 with b from 0 to 15, or that is all ones, sets `err_o` with the result. The bin is then the run length from bit 0, capped at 15.
- R9: When the stop arrives with k-1 of 2048 or more, `ovf_o` is set and `stamp_o` is 0x7FFF. With k-1 = 2047, `ovf_o` stays clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; both edges are used |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start event pulse, sampled on the rising edge |
| stop_i | input | 1 | Stop event pulse, sampled on the rising edge |
| taps_i | input | 16 | Sampled delay-line taps, valid with `stop_i` |
| valid_o | output | 1 | One-cycle result strobe |
| stamp_o | output | 15 | Timestamp: coarse periods above fine bin |
| ovf_o | output | 1 | Coarse range exceeded for this result |
| err_o | output | 1 | Tap snapshot was not a clean thermometer code |

## Verification
A stop sampled on rising edge k is captured on that edge. Its timestamp, flags and strobe appear on rising edge k+1, and the flags hold after that. The reference model in the bench steps once per rising edge with the same inputs. Its result goes into a one-deep pending slot on the stop edge and comes out to the expected outputs on the next edge. The bench compares all outputs against the model one nanosecond after every rising edge, so an output that comes a cycle early or late is reported. Hand-computed timestamps for the bins next to each clock edge and for the overflow boundary are also checked.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  localparam int unsigned DEF_TAPS    = 16;
  localparam int unsigned DEF_COARSE  = 11;

  function automatic int unsigned bits_for(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tdc_therm_enc.sv
module tdc_therm_enc #(
  parameter int unsigned TAPS = tdc_pkg::DEF_TAPS,
  localparam int unsigned BW  = tdc_pkg::bits_for(TAPS)
) (
  input  logic [TAPS-1:0] taps_i,
  output logic [BW-1:0]   bin_o,
  output logic            err_o
);
  logic [BW:0] run_len;
  logic        in_run;

  always_comb begin
    run_len = '0;
    in_run  = 1'b1;
    for (int i = 0; i < int'(TAPS); i++) begin
      if (in_run && taps_i[i]) run_len = run_len + 1'b1;
      else                     in_run  = 1'b0;
    end
  end

  assign bin_o = run_len[BW] ? {BW{1'b1}} : run_len[BW-1:0];
  assign err_o = ((taps_i & (taps_i + 1'b1)) != '0) || (&taps_i);

  always_comb begin
    if (!err_o) begin
      AST_THERM_EXACT: assert (taps_i == ((TAPS'(1) << bin_o) - TAPS'(1))); // R3
    end
  end
endmodule

// File: rtl/tdc_dual_counter.sv
module tdc_dual_counter #(
  parameter int unsigned CW = tdc_pkg::DEF_COARSE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          armed_i,
  output logic [CW-1:0] rise_cnt_o,
  output logic [CW-1:0] fall_cnt_o,
  output logic          wrap_o
);
  logic first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_cnt_o <= '0;
      first_q    <= 1'b0;
    end else begin
      first_q <= start_i;
      if (start_i)      rise_cnt_o <= '0;
      else if (armed_i) rise_cnt_o <= rise_cnt_o + 1'b1;
    end
  end

  always_ff @(negedge clk) begin
    if (rst)          fall_cnt_o <= '0;
    else if (first_q) fall_cnt_o <= CW'(1);
    else if (armed_i) fall_cnt_o <= fall_cnt_o + 1'b1;
  end

  assign wrap_o = armed_i && !start_i && (&rise_cnt_o);

  AST_FALL_AHEAD: assert property (@(posedge clk) disable iff (rst)
    (armed_i && !first_q) |-> (fall_cnt_o == rise_cnt_o + CW'(1))); // R4
endmodule

// File: rtl/tdc_coarse_fine_enc.sv
module tdc_coarse_fine_enc #(
  parameter int unsigned TAPS = tdc_pkg::DEF_TAPS,
  parameter int unsigned CW   = tdc_pkg::DEF_COARSE,
  localparam int unsigned BW  = tdc_pkg::bits_for(TAPS),
  localparam int unsigned OW  = CW + BW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic [TAPS-1:0] taps_i,
  output logic            valid_o,
  output logic [OW-1:0]   stamp_o,
  output logic            ovf_o,
  output logic            err_o
);
  logic          armed, ovf_run;
  logic [CW-1:0] rise_cnt, fall_cnt;
  logic          wrap;
  logic [BW-1:0] enc_bin;
  logic          enc_err;

  logic          cap_v, cap_err, cap_ovf;
  logic [CW-1:0] cap_rise, cap_fall;
  logic [BW-1:0] cap_bin;
  logic [CW-1:0] coarse_sel;

  tdc_dual_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .start_i(start_i), .armed_i(armed),
    .rise_cnt_o(rise_cnt), .fall_cnt_o(fall_cnt), .wrap_o(wrap)
  );

  tdc_therm_enc #(.TAPS(TAPS)) u_enc (
    .taps_i(taps_i), .bin_o(enc_bin), .err_o(enc_err)
  );

  // Early half of the period: rising counter may be mid-switch, use the falling one.
  assign coarse_sel = cap_bin[BW-1] ? cap_rise : (cap_fall - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      ovf_run  <= 1'b0;
      cap_v    <= 1'b0;
      cap_err  <= 1'b0;
      cap_ovf  <= 1'b0;
      cap_rise <= '0;
      cap_fall <= '0;
      cap_bin  <= '0;
      valid_o  <= 1'b0;
      stamp_o  <= '0;
      ovf_o    <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      cap_v <= 1'b0;
      if (start_i) begin
        armed   <= 1'b1;
        ovf_run <= 1'b0;
      end else if (armed) begin
        if (wrap) ovf_run <= 1'b1;
        if (stop_i) begin
          armed    <= 1'b0;
          cap_v    <= 1'b1;
          cap_rise <= rise_cnt;
          cap_fall <= fall_cnt;
          cap_bin  <= enc_bin;
          cap_err  <= enc_err;
          cap_ovf  <= ovf_run;
        end
      end
      valid_o <= cap_v;
      if (cap_v) begin
        stamp_o <= cap_ovf ? {OW{1'b1}} : {coarse_sel, cap_bin};
        ovf_o   <= cap_ovf;
        err_o   <= cap_err;
      end
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!valid_o && !ovf_o && !err_o)); // R1
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R5
  AST_SAT_STAMP: assert property (@(posedge clk) disable iff (rst)
    (valid_o && ovf_o) |-> (&stamp_o)); // R9
  AST_STOP_DISARMS: assert property (@(posedge clk) disable iff (rst)
    (armed && stop_i && !start_i) |=> ##1 valid_o); // R6
endmodule

// File: tb/tdc_coarse_fine_enc_tb.sv
module tdc_coarse_fine_enc_tb;
  logic        clk = 1'b0;
  logic        rst, start, stop;
  logic [15:0] taps;
  logic        valid_o, ovf_o, err_o;
  logic [14:0] stamp_o;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  // model state
  bit m_armed = 0, m_pend = 0;
  int m_k = 0;
  bit e_valid = 0, e_ovf = 0, e_err = 0;
  int e_stamp = 0, p_stamp = 0;
  bit p_ovf = 0, p_err = 0;
  int last_stamp = -1;
  bit last_ovf = 0, last_err = 0;

  always #5 clk = ~clk;

  tdc_coarse_fine_enc u_dut (
    .clk(clk), .rst(rst), .start_i(start), .stop_i(stop), .taps_i(taps),
    .valid_o(valid_o), .stamp_o(stamp_o), .ovf_o(ovf_o), .err_o(err_o)
  );

  task automatic model_step();
    if (rst) begin
      m_armed = 0; m_pend = 0; m_k = 0;
      e_valid = 0; e_stamp = 0; e_ovf = 0; e_err = 0;
    end else begin
      e_valid = m_pend;
      if (m_pend) begin
        e_stamp = p_stamp; e_ovf = p_ovf; e_err = p_err;
      end
      m_pend = 0;
      if (start) begin
        m_armed = 1; m_k = 0;
      end else if (m_armed) begin
        m_k++;
        if (stop) begin
          int run = 0;
          int c;
          for (int i = 0; i < 16; i++) if (taps[i] && run == i) run++;
          p_err = !((int'(taps) == ((1 << run) - 1)) && run < 16);
          c = m_k - 1;
          p_ovf = (c > 2047);
          p_stamp = p_ovf ? 32767 : c * 16 + ((run > 15) ? 15 : run);
          m_pend = 1; m_armed = 0;
        end
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
    checks++;
    if ({valid_o, stamp_o, ovf_o, err_o} !== {e_valid, 15'(e_stamp), e_ovf, e_err}) begin
      errors++;
      $display("FAIL %s: act v=%0b s=%0d o=%0b e=%0b exp v=%0b s=%0d o=%0b e=%0b",
               cur_req, valid_o, stamp_o, ovf_o, err_o, e_valid, e_stamp, e_ovf, e_err);
    end
    if (valid_o) begin
      last_stamp = stamp_o; last_ovf = ovf_o; last_err = err_o;
    end
    #1;
  endtask

  task automatic check_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // start, then stop on the k-th rising edge after the start edge
  task automatic measure(int k, logic [15:0] t);
    last_stamp = -1;
    start = 1; tick(); start = 0;
    for (int i = 1; i < k; i++) tick();
    stop = 1; taps = t; tick(); stop = 0; taps = '0;
    tick(); tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1; start = 0; stop = 0; taps = '0;
    #2;
    cur_req = "R1";
    tick(); tick();
    check_eq("R1", int'(stamp_o), 0);
    rst = 0; tick();

    cur_req = "R2";
    measure(5, 16'h0000);
    check_eq("R2", last_stamp, 4 * 16 + 0);
    cur_req = "R4";
    measure(5, 16'h00FF);
    check_eq("R4", last_stamp, 4 * 16 + 8);
    measure(1, 16'h007F);
    check_eq("R4", last_stamp, 7);
    measure(3, 16'h7FFF);
    check_eq("R4", last_stamp, 2 * 16 + 15);
    cur_req = "R3";
    measure(2, 16'h0001);
    check_eq("R3", last_stamp, 16 + 1);
    measure(9, 16'h0FFF);
    check_eq("R3", last_stamp, 8 * 16 + 12);

    cur_req = "R8";
    measure(4, 16'h00F7);
    check_eq("R8", last_stamp, 3 * 16 + 3);
    check_eq("R8", int'(last_err), 1);
    measure(4, 16'hFFFF);
    check_eq("R8", last_stamp, 3 * 16 + 15);
    check_eq("R8", int'(last_err), 1);
    measure(4, 16'h0003);
    check_eq("R8", int'(last_err), 0);

    cur_req = "R6";
    stop = 1; taps = 16'h0007; tick(); stop = 0; tick(); tick();
    check_eq("R6", int'(valid_o), 0);
    start = 1; stop = 1; tick(); start = 0; stop = 0;
    tick(); tick();
    check_eq("R6", int'(valid_o), 0);
    stop = 1; taps = 16'h0003; tick(); stop = 0;
    tick(); check_eq("R6", last_stamp, 2 * 16 + 2);
    stop = 1; tick(); stop = 0; tick(); tick();
    check_eq("R6", int'(valid_o), 0);

    cur_req = "R7";
    last_stamp = -1;
    start = 1; tick(); start = 0; tick(); tick(); tick();
    measure(4, 16'h01FF);
    check_eq("R7", last_stamp, 3 * 16 + 9);

    cur_req = "R5";
    tick(); tick();
    check_eq("R5", int'(stamp_o), 3 * 16 + 9);
    check_eq("R5", int'(valid_o), 0);

    cur_req = "R9";
    measure(2048, 16'h7FFF);
    check_eq("R9", last_stamp, 32767);
    check_eq("R9", int'(last_ovf), 0);
    measure(2049, 16'h0007);
    check_eq("R9", last_stamp, 32767);
    check_eq("R9", int'(last_ovf), 1);
    measure(2, 16'h0000);
    check_eq("R9", int'(last_ovf), 0);

    cur_req = "R1";
    start = 1; tick(); start = 0; tick();
    rst = 1; tick(); rst = 0;
    stop = 1; taps = 16'h000F; tick(); stop = 0; tick(); tick();
    check_eq("R1", int'(valid_o), 0);
    check_eq("R1", int'(stamp_o), 0);
    check_eq("R1", int'(ovf_o), 0);

    finish_run();
  end
endmodule